// File: doc/BRIEF.md
# Compare-and-Branch Resolver

This block resolves the branch class of a small 64-bit virtual-machine instruction set. For each operation code it decides whether control leaves the fall-through path. It evaluates one of eleven conditions between the destination operand and a right-hand operand. The conditions cover equality, inequality, unsigned ordering, two's-complement ordering and a bit-test. The right-hand operand is either the source register value or the sign-extended immediate, chosen by a single select bit.

The resolver also computes the next program counter. A taken branch goes to PC + 1 + offset, where the signed offset counts instruction words. A branch that is not taken goes to PC + 1. The block also recognises the call, return-to-caller and always-jump encodings and reports them to the sequencer. A call is reported together with its raw immediate target field. Codes that the class does not define raise an illegal flag.

Operand, immediate, offset and PC widths are parameters. A parameter selects a registered or a pass-through output stage. A second parameter selects how the signed orderings are built.

Top module: `cmpbr_unit`

## Requirements
- R1: Code 0 (always) is taken regardless of operands, and its next PC is PC + 1 + offset.
- R2: With select = 1 the right-hand operand is the source value. With select = 0 it is the immediate, sign-extended from IMM_W to DATA_W bits.
- R3: Code 1 is taken when both operands are equal. Code 5 is taken when they differ.
- R4: Codes 2, 3, 10 and 11 are taken on destination >, >=, < and <= the right-hand operand, all compared unsigned.
- R5: Codes 6, 7, 12 and 13 are taken on destination >, >=, < and <= the right-hand operand, all compared as two's complement.
- R6: Code 4 is taken when the bitwise AND of the two operands is nonzero.
- R7: When taken, the next PC is (PC + 1 + sign-extended offset) modulo 2^PC_W. Otherwise it is (PC + 1) modulo 2^PC_W.
- R8: Code 8 raises the call flag and presents the raw immediate on the call target output. It is not taken, and its next PC is PC + 1.
- R9: Code 9 raises the exit flag. It is not taken.
- R10: Codes 14 and 15 raise the illegal flag. They are not taken and raise neither call nor exit.
- R11: At most one of taken, call, exit and illegal is high in any cycle.
- R12: With REG_OUT = 1, every output is zero while reset is asserted. The results of the inputs present at a clock edge appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Branch-class operation code |
| src_sel_i | input | 1 | 1 selects the source value, 0 selects the immediate |
| dst_val_i | input | DATA_W | Destination register value (left-hand operand) |
| src_val_i | input | DATA_W | Source register value |
| imm_i | input | IMM_W | Immediate field |
| ofs_i | input | OFS_W | Signed word offset |
| pc_i | input | PC_W | Current program counter, in instruction words |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | PC_W | Next program counter |
| call_o | output | 1 | Call request |
| call_tgt_o | output | IMM_W | Raw immediate target field of a call |
| exit_o | output | 1 | Exit request |
| illegal_o | output | 1 | Undefined code in this class |

## Verification
The bench builds the block with DATA_W = 6, IMM_W = 4, OFS_W = 4, PC_W = 8 and the registered output stage. At these widths it can sweep every operation code, both select values and every operand pair: 64 x 64 for register operands and 64 x 16 for immediates. Every sign boundary of the signed and unsigned orderings is therefore hit exactly. The 4-bit immediate is narrower than the operand, so sign extension shows in the comparisons. The offset and PC vary with the operands, so next-PC wraparound occurs in both directions.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;

   typedef enum logic [3:0] {
      OP_ALWAYS = 4'h0,
      OP_EQ     = 4'h1,
      OP_UGT    = 4'h2,
      OP_UGE    = 4'h3,
      OP_BITS   = 4'h4,
      OP_NE     = 4'h5,
      OP_SGT    = 4'h6,
      OP_SGE    = 4'h7,
      OP_CALL   = 4'h8,
      OP_EXIT   = 4'h9,
      OP_ULT    = 4'hA,
      OP_ULE    = 4'hB,
      OP_SLT    = 4'hC,
      OP_SLE    = 4'hD,
      OP_RSV_E  = 4'hE,
      OP_RSV_F  = 4'hF
   } br_op_e;

   typedef struct packed {
      logic taken;
      logic call;
      logic quit;
      logic bad;
   } br_flags_t;

endpackage

// File: rtl/cmpbr_opsel.sv
module cmpbr_opsel #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32
) (
   input  logic              src_sel_i,
   input  logic [DATA_W-1:0] src_val_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] rhs_o
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (IMM_W > DATA_W) begin : g_bad_cfg
         $error("cmpbr_opsel: IMM_W must not exceed DATA_W");
      end
      if (EXT_W == 0) begin : g_no_ext
         assign imm_ext = imm_i;
      end else begin : g_ext
         assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      end
   endgenerate

   assign rhs_o = src_sel_i ? src_val_i : imm_ext;

endmodule

// File: rtl/cmpbr_cond.sv
module cmpbr_cond
   import cmpbr_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter bit SIGNED_FLIP = 1'b1
) (
   input  br_op_e            op_i,
   input  logic [DATA_W-1:0] lhs_i,
   input  logic [DATA_W-1:0] rhs_i,
   output logic              hit_o
);
   localparam int MSB = DATA_W - 1;

   logic eq, ult, slt, any_bit;

   assign eq      = (lhs_i == rhs_i);
   assign ult     = (lhs_i < rhs_i);
   assign any_bit = |(lhs_i & rhs_i);

   generate
      if (DATA_W < 2) begin : g_bad_cfg
         $error("cmpbr_cond: DATA_W must be at least 2");
      end
      if (SIGNED_FLIP) begin : g_flip
         logic [DATA_W-1:0] lhs_b, rhs_b;
         assign lhs_b = {~lhs_i[MSB], lhs_i[MSB-1:0]};
         assign rhs_b = {~rhs_i[MSB], rhs_i[MSB-1:0]};
         assign slt   = (lhs_b < rhs_b);
      end else begin : g_native
         assign slt = ($signed(lhs_i) < $signed(rhs_i));
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_ALWAYS: hit_o = 1'b1;
         OP_EQ:     hit_o = eq;
         OP_NE:     hit_o = ~eq;
         OP_UGT:    hit_o = ~ult & ~eq;
         OP_UGE:    hit_o = ~ult;
         OP_ULT:    hit_o = ult;
         OP_ULE:    hit_o = ult | eq;
         OP_SGT:    hit_o = ~slt & ~eq;
         OP_SGE:    hit_o = ~slt;
         OP_SLT:    hit_o = slt;
         OP_SLE:    hit_o = slt | eq;
         OP_BITS:   hit_o = any_bit;
         default:   hit_o = 1'b0;
      endcase
   end

   // R4 R5: equal operands can be neither strictly below the other
   always_comb begin
      eq_order_chk : assert (!(eq && (ult || slt)));
   end

endmodule

// File: rtl/cmpbr_target.sv
module cmpbr_target #(
   parameter int PC_W  = 32,
   parameter int OFS_W = 16
) (
   input  logic [PC_W-1:0]  pc_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             take_i,
   output logic [PC_W-1:0]  next_pc_o
);
   localparam int EXT_W = PC_W - OFS_W;

   logic [PC_W-1:0] ofs_ext, pc_inc, pc_jmp;

   generate
      if (OFS_W > PC_W) begin : g_bad_cfg
         $error("cmpbr_target: OFS_W must not exceed PC_W");
      end
      if (EXT_W == 0) begin : g_no_ext
         assign ofs_ext = ofs_i;
      end else begin : g_ext
         assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
      end
   endgenerate

   assign pc_inc    = pc_i + PC_W'(1);
   assign pc_jmp    = pc_inc + ofs_ext;
   assign next_pc_o = take_i ? pc_jmp : pc_inc;

endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
   import cmpbr_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int IMM_W       = 32,
   parameter int OFS_W       = 16,
   parameter int PC_W        = 32,
   parameter bit REG_OUT     = 1'b1,
   parameter bit SIGNED_FLIP = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [3:0]        op_i,
   input  logic              src_sel_i,
   input  logic [DATA_W-1:0] dst_val_i,
   input  logic [DATA_W-1:0] src_val_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [PC_W-1:0]   pc_i,
   output logic              taken_o,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              call_o,
   output logic [IMM_W-1:0]  call_tgt_o,
   output logic              exit_o,
   output logic              illegal_o
);
   localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

   br_op_e            op;
   logic [DATA_W-1:0] rhs;
   logic              hit;
   br_flags_t         flg_c;
   logic [PC_W-1:0]   npc_c;

   assign op = br_op_e'(op_i);

   cmpbr_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .src_sel_i (src_sel_i),
      .src_val_i (src_val_i),
      .imm_i     (imm_i),
      .rhs_o     (rhs)
   );

   cmpbr_cond #(.DATA_W(DATA_W), .SIGNED_FLIP(SIGNED_FLIP)) u_cond (
      .op_i  (op),
      .lhs_i (dst_val_i),
      .rhs_i (rhs),
      .hit_o (hit)
   );

   always_comb begin
      flg_c       = '0;
      flg_c.taken = hit;
      flg_c.call  = (op == OP_CALL);
      flg_c.quit  = (op == OP_EXIT);
      flg_c.bad   = (op == OP_RSV_E) || (op == OP_RSV_F);
   end

   cmpbr_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
      .pc_i      (pc_i),
      .ofs_i     (ofs_i),
      .take_i    (flg_c.taken),
      .next_pc_o (npc_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         br_flags_t        flg_q;
         logic [PC_W-1:0]  npc_q;
         logic [IMM_W-1:0] tgt_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               flg_q <= '0;
               npc_q <= '0;
               tgt_q <= '0;
            end else begin
               flg_q <= flg_c;
               npc_q <= npc_c;
               tgt_q <= flg_c.call ? imm_i : '0;
            end
         end

         assign taken_o    = flg_q.taken;
         assign call_o     = flg_q.call;
         assign exit_o     = flg_q.quit;
         assign illegal_o  = flg_q.bad;
         assign next_pc_o  = npc_q;
         assign call_tgt_o = tgt_q;

         // R11
         flag_excl_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({taken_o, call_o, exit_o, illegal_o}));
         // R1
         always_take_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (op_i == 4'h0) |=> taken_o);
         // R8
         call_tgt_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (op_i == 4'h8) |=> (call_o && !taken_o && call_tgt_o == $past(imm_i)));
         // R9
         exit_flag_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (op_i == 4'h9) |=> (exit_o && !taken_o));
         // R10
         illegal_op_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (op_i >= 4'hE) |=> (illegal_o && !taken_o && !call_o && !exit_o));
         // R7
         fallthru_pc_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && !taken_o) |-> (next_pc_o == $past(pc_i) + PC_ONE));
      end else begin : g_comb
         assign taken_o    = flg_c.taken;
         assign call_o     = flg_c.call;
         assign exit_o     = flg_c.quit;
         assign illegal_o  = flg_c.bad;
         assign next_pc_o  = npc_c;
         assign call_tgt_o = flg_c.call ? imm_i : '0;
      end
   endgenerate

endmodule

// File: tb/cmpbr_unit_bench.sv
`timescale 1ns/1ps
module cmpbr_unit_bench;
   localparam int DW = 6;
   localparam int IW = 4;
   localparam int OW = 4;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    op = '0;
   logic          sel = 1'b0;
   logic [DW-1:0] dv = '0, sv = '0;
   logic [IW-1:0] imm = '0;
   logic [OW-1:0] ofs = '0;
   logic [PW-1:0] pc = '0;
   logic          tk, cl, ex, il;
   logic [PW-1:0] npc;
   logic [IW-1:0] tgt;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cmpbr_unit #(.DATA_W(DW), .IMM_W(IW), .OFS_W(OW), .PC_W(PW),
                .REG_OUT(1'b1), .SIGNED_FLIP(1'b1)) u_cmpbr_unit (
      .clk_i(clk), .rst_ni(rst_n), .op_i(op), .src_sel_i(sel),
      .dst_val_i(dv), .src_val_i(sv), .imm_i(imm), .ofs_i(ofs), .pc_i(pc),
      .taken_o(tk), .next_pc_o(npc), .call_o(cl), .call_tgt_o(tgt),
      .exit_o(ex), .illegal_o(il)
   );

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'h0:                      return "R1";
         4'h1, 4'h5:                return "R3";
         4'h2, 4'h3, 4'hA, 4'hB:    return "R4";
         4'h6, 4'h7, 4'hC, 4'hD:    return "R5";
         4'h4:                      return "R6";
         4'h8:                      return "R8";
         4'h9:                      return "R9";
         default:                   return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s op=%h sel=%b d=%h s=%h imm=%h ofs=%h pc=%h actual=%h expected=%h",
                  req, op, sel, dv, sv, imm, ofs, pc, act, exp);
      end
   endtask

   task automatic run_vec();
      logic [DW-1:0] rhs;
      logic          e_tk, e_cl, e_ex, e_il;
      logic [PW-1:0] e_npc;
      logic [IW-1:0] e_tgt;
      string         tg;
      // R2: immediate sign-extended to operand width
      rhs = sel ? sv : {{(DW-IW){imm[IW-1]}}, imm};
      e_tk = 0; e_cl = 0; e_ex = 0; e_il = 0;
      case (op)
         4'h0: e_tk = 1;
         4'h1: e_tk = (dv == rhs);
         4'h5: e_tk = (dv != rhs);
         4'h2: e_tk = (dv >  rhs);
         4'h3: e_tk = (dv >= rhs);
         4'hA: e_tk = (dv <  rhs);
         4'hB: e_tk = (dv <= rhs);
         4'h6: e_tk = ($signed(dv) >  $signed(rhs));
         4'h7: e_tk = ($signed(dv) >= $signed(rhs));
         4'hC: e_tk = ($signed(dv) <  $signed(rhs));
         4'hD: e_tk = ($signed(dv) <= $signed(rhs));
         4'h4: e_tk = ((dv & rhs) != '0);
         4'h8: e_cl = 1;
         4'h9: e_ex = 1;
         default: e_il = 1;
      endcase
      e_tgt = e_cl ? imm : '0;
      e_npc = pc + PW'(1) + (e_tk ? {{(PW-OW){ofs[OW-1]}}, ofs} : '0);
      @(posedge clk);
      @(negedge clk);
      tg = sel ? tag_of(op) : {tag_of(op), "/R2"};
      check(tg, {28'd0, tk, cl, ex, il}, {28'd0, e_tk, e_cl, e_ex, e_il});
      check("R7", 32'(npc), 32'(e_npc));
      if (op == 4'h8) check("R8", 32'(tgt), 32'(e_tgt));
      // R11
      check("R11", 32'(int'(tk) + int'(cl) + int'(ex) + int'(il) <= 1), 32'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      op = 4'h0;
      dv = '1;
      pc = 8'h55;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: outputs held at zero during reset
      check("R12", {23'd0, tk, cl, ex, il, tgt}, 32'd0);
      check("R12", 32'(npc), 32'd0);
      rst_n = 1'b1;
      for (int o = 0; o < 16; o++) begin
         for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 64; a++) begin
               for (int b = 0; b < (s ? 64 : 16); b++) begin
                  op  = 4'(o);
                  sel = s[0];
                  dv  = DW'(a);
                  sv  = DW'(b);
                  imm = IW'(b);
                  ofs = OW'(a ^ b ^ o);
                  pc  = PW'(a * 3 + b * 17 + o);
                  run_vec();
               end
            end
         end
      end
      // R12: reset returns outputs to zero
      op = 4'h0;
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R12", {27'd0, tk, cl, ex, il, 1'b0}, 32'd0);
      finish_run();
   end

endmodule